// File: doc/BRIEF.md
# Host Bus Register Interface

This block connects an 8-bit host processor bus to a communications controller. The host drives chip select, read strobe, write strobe (all active low), a 3-bit address and a data byte. Every signal is brought into the internal clock domain through a two-stage synchroniser, and an access takes effect once, when its strobe is released. Each address reaches a direct register or a byte FIFO, and a read and a write to the same address can reach different targets. The host data bus is bidirectional at the pins. In this block it is split into `data_i`, `data_o` and the drive enable `data_oe_o`.

Behind the direct ports sit three transmit/receive FIFO pairs, one per channel, and a two-entry error FIFO. The controller core reaches them through plain push and pop ports. An indirect register bank of 8 groups is also behind them. The host reaches it by writing a command byte that names a group and an offset. It then moves bytes through the data port, and the offset steps forward within the group after each byte. A sticky interrupt register gathers underflow, overflow, protocol-error and external events. A read of that register clears it. `irq_o` stays high while any bit of the register is set and not masked.

Top module: `hbus_regif`

## Requirements
- R1: While `cs_ni` is high for a whole strobe, the access has no effect. No FIFO is pushed or popped, the interrupt register is not cleared and the command register is not written.
- R2: A read of address 0 returns the interrupt register. The register is cleared when the read strobe is released, unless an event sets a bit in that same cycle. The bits are: 0 = underflow, 1 = overflow, 2 = protocol error, 7:3 = `irq_src_i[4:0]`, and each bit stays set until the register is read.
- R3: A write of address 0 loads the command byte. Bits 5:3 select the group, bits 2:0 select the offset, and bits 7:6 must be 00 to open a transfer. A read or write of address 1 reaches byte (group, offset). After each such access the offset advances, and it returns to 0 after the last byte of the group. The length of group g is 2·((g mod 4)+1) bytes. An access at an offset at or beyond the group length reads 0x00, is not written, and moves the offset to 0.
- R4: Every command write ends the transfer in progress and restarts at the new offset. A command with bits 7:6 not 00 leaves no transfer open. Address-1 reads then return 0x00 and address-1 writes change nothing until the next valid command. After reset no transfer is open.
- R5: A read of address 2 returns `stat1_i` and a read of address 7 returns `stat2_i`. Writes to addresses 2, 3 and 7 have no effect.
- R6: A read of address 3 pops the 2-entry error FIFO, which the core fills through `err_push_i`. The bytes come out in arrival order.
- R7: A write of address 4, 5 or 6 pushes the transmit FIFO of channel 0, 1 or 2. A read of the same address pops that channel's receive FIFO. Each strobe pushes or pops exactly once. Channel 0 holds 8 bytes and channels 1 and 2 hold 4.
- R8: A host pop of an empty FIFO returns 0x00 and sets interrupt bit 0. A push to a full FIFO, from the host or from the core, drops the byte and sets interrupt bit 1.
- R9: A strobe window in which read and write are both low while the block is selected performs no access and sets interrupt bit 2.
- R10: `irq_o` is high exactly when some interrupt bit is 1 and its mask bit is 0. The mask is indirect byte (group 0, offset 0).
- R11: After reset the interrupt register is 0, all FIFOs are empty, `irq_o` is low and the indirect bank is 0.
- R12: `data_oe_o` is high only while `cs_ni` and `rd_ni` are low and `wr_ni` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Host chip select, active low |
| rd_ni | input | 1 | Host read strobe, active low |
| wr_ni | input | 1 | Host write strobe, active low |
| addr_i | input | 3 | Host address |
| data_i | input | 8 | Host write data |
| data_o | output | 8 | Host read data |
| data_oe_o | output | 1 | Host bus drive enable |
| irq_o | output | 1 | Interrupt request, active high |
| ctx_pop_i | input | 3 | Core pop, transmit FIFO per channel |
| ctx_data_o | output | 24 | Transmit FIFO head per channel |
| ctx_empty_o | output | 3 | Transmit FIFO empty per channel |
| crx_push_i | input | 3 | Core push, receive FIFO per channel |
| crx_data_i | input | 24 | Receive FIFO write data per channel |
| crx_full_o | output | 3 | Receive FIFO full per channel |
| err_push_i | input | 1 | Core push into error FIFO |
| err_data_i | input | 8 | Error FIFO write data |
| stat1_i | input | 8 | Status byte returned at address 2 |
| stat2_i | input | 8 | Status byte returned at address 7 |
| irq_src_i | input | 5 | External interrupt events, one cycle each |
| bank_o | output | 512 | Indirect bank contents, byte 8·group+offset |

## Verification
Some corner cases can only be reached through the indirect pointer. One is a command that lands past the end of a short group, and another is a transfer that wraps inside a group. The bench reaches these with directed command bytes, then fills the bank with random commands and transfers checked against a bench model of the pointer. The overlapped-strobe case cannot arise in normal host traffic, so a dedicated task drives both strobes low together on a FIFO address. The bench then checks that the FIFO stayed empty. Overflow and underflow come from directed fills beyond depth and from pops of empty FIFOs, and the random mix of core and host traffic reaches them again.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  localparam int unsigned BW = 8;
  typedef logic [BW-1:0] byte_t;

  typedef enum logic [2:0] {
    A_CMD_IR = 3'd0,
    A_DATA   = 3'd1,
    A_STAT1  = 3'd2,
    A_ERR    = 3'd3,
    A_CH_D   = 3'd4,
    A_CH_BB  = 3'd5,
    A_CH_BC  = 3'd6,
    A_STAT2  = 3'd7
  } host_addr_e;

  localparam int unsigned IR_UNDER = 0;
  localparam int unsigned IR_OVER  = 1;
  localparam int unsigned IR_PROTO = 2;
  localparam int unsigned IR_EXT   = 3;

  // bytes in group g: quarter steps of the full group size
  function automatic int unsigned grp_len(int unsigned g, int unsigned gsz);
    return ((g % 4) + 1) * gsz / 4;
  endfunction
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int unsigned AW = 3,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          rd_ni,
  input  logic          wr_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          rd_ev_o,
  output logic          wr_ev_o,
  output logic          bad_o,
  output logic [AW-1:0] ev_addr_o,
  output logic [DW-1:0] ev_data_o
);
  logic [1:0]         cs_q, rd_q, wr_q;
  logic [1:0][AW-1:0] a_q;
  logic [1:0][DW-1:0] d_q;
  logic cs_s, rd_s, wr_s, act, act_q, bad_now, bad_seen;
  logic lat_rd, lat_wr, lat_sel, ev;

  assign cs_s    = cs_q[1];
  assign rd_s    = rd_q[1];
  assign wr_s    = wr_q[1];
  assign act     = ~rd_s | ~wr_s;
  assign bad_now = ~cs_s & ~rd_s & ~wr_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q      <= '1;
      rd_q      <= '1;
      wr_q      <= '1;
      a_q       <= '0;
      d_q       <= '0;
      act_q     <= 1'b0;
      bad_seen  <= 1'b0;
      lat_rd    <= 1'b0;
      lat_wr    <= 1'b0;
      lat_sel   <= 1'b0;
      ev_addr_o <= '0;
      ev_data_o <= '0;
    end else begin
      cs_q     <= {cs_q[0], cs_ni};
      rd_q     <= {rd_q[0], rd_ni};
      wr_q     <= {wr_q[0], wr_ni};
      a_q      <= {a_q[0], addr_i};
      d_q      <= {d_q[0], data_i};
      act_q    <= act;
      bad_seen <= act & (bad_seen | bad_now);
      if (act) begin
        // accumulate over the whole strobe window
        lat_rd    <= ~rd_s | (act_q & lat_rd);
        lat_wr    <= ~wr_s | (act_q & lat_wr);
        lat_sel   <= ~cs_s | (act_q & lat_sel);
        ev_addr_o <= a_q[1];
        ev_data_o <= d_q[1];
      end
    end
  end

  assign ev      = act_q & ~act;
  assign rd_ev_o = ev & lat_sel & lat_rd & ~lat_wr;
  assign wr_ev_o = ev & lat_sel & lat_wr & ~lat_rd;
  assign bad_o   = bad_now & ~bad_seen;

  a_r9_bad_no_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_o |=> !(rd_ev_o || wr_ev_o));
  a_r7_single_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ev_o || wr_ev_o) |=> !(rd_ev_o || wr_ev_o));
endmodule

// File: rtl/hbus_fifo.sv
module hbus_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == CW'(DEPTH));
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign rdata_o = empty_o ? '0 : mem[rp];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp] <= wdata_i;
  end

  a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> cnt == $past(cnt));
  a_r7_one_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !empty_o && !push_i) |=> cnt == $past(cnt) - 1'b1);
  a_r8_empty_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> empty_o);
endmodule

// File: rtl/hbus_ind.sv
module hbus_ind
  import hbus_pkg::*;
#(
  parameter int unsigned NUM_GRP = 8,   // power of two
  parameter int unsigned GRP_SZ  = 8    // power of two, multiple of 4
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  cmd_wr_i,
  input  logic  dat_wr_i,
  input  logic  dat_rd_i,
  input  byte_t wdata_i,
  output byte_t rdata_o,
  output logic [NUM_GRP*GRP_SZ-1:0][BW-1:0] bank_o
);
  localparam int unsigned GW = $clog2(NUM_GRP);
  localparam int unsigned OW = $clog2(GRP_SZ);
  localparam int unsigned LW = OW + 1;
  localparam int unsigned NB = NUM_GRP * GRP_SZ;

  logic [NB-1:0][BW-1:0] bank_q;
  logic                  act_q, cmd_ok, in_rng;
  logic [GW-1:0]         grp_q;
  logic [OW-1:0]         off_q, nxt_off;
  logic [LW-1:0]         len;
  logic [GW+OW-1:0]      idx;

  always_comb len = LW'(grp_len(int'(grp_q), GRP_SZ));
  assign idx     = {grp_q, off_q};
  assign in_rng  = act_q & ({1'b0, off_q} < len);
  assign cmd_ok  = (wdata_i >> (GW + OW)) == '0;
  assign nxt_off = (({1'b0, off_q} + 1'b1) >= len) ? '0 : off_q + 1'b1;
  assign rdata_o = in_rng ? bank_q[idx] : '0;
  assign bank_o  = bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      grp_q  <= '0;
      off_q  <= '0;
      bank_q <= '0;
    end else if (cmd_wr_i) begin
      act_q <= cmd_ok;
      grp_q <= wdata_i[GW+OW-1:OW];
      off_q <= wdata_i[OW-1:0];
    end else if ((dat_wr_i || dat_rd_i) && act_q) begin
      if (dat_wr_i && in_rng) bank_q[idx] <= wdata_i;
      off_q <= nxt_off;
    end
  end

  a_r3_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_wr_i && !cmd_wr_i && in_rng) |=> bank_q[$past(idx)] == $past(wdata_i));
  a_r4_cancel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && !cmd_ok) |=> rdata_o == '0);
  a_r3_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_rd_i && !cmd_wr_i && act_q && (({1'b0, off_q} + 1'b1) >= len)) |=> off_q == '0);
endmodule

// File: rtl/hbus_regif.sv
module hbus_regif
  import hbus_pkg::*;
#(
  parameter int unsigned D_DEPTH   = 8,
  parameter int unsigned B_DEPTH   = 4,
  parameter int unsigned ERR_DEPTH = 2,
  parameter int unsigned NUM_GRP   = 8,
  parameter int unsigned GRP_SZ    = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             cs_ni,
  input  logic                             rd_ni,
  input  logic                             wr_ni,
  input  logic [2:0]                       addr_i,
  input  logic [7:0]                       data_i,
  output logic [7:0]                       data_o,
  output logic                             data_oe_o,
  output logic                             irq_o,
  input  logic [2:0]                       ctx_pop_i,
  output logic [2:0][7:0]                  ctx_data_o,
  output logic [2:0]                       ctx_empty_o,
  input  logic [2:0]                       crx_push_i,
  input  logic [2:0][7:0]                  crx_data_i,
  output logic [2:0]                       crx_full_o,
  input  logic                             err_push_i,
  input  logic [7:0]                       err_data_i,
  input  logic [7:0]                       stat1_i,
  input  logic [7:0]                       stat2_i,
  input  logic [4:0]                       irq_src_i,
  output logic [NUM_GRP*GRP_SZ-1:0][7:0]   bank_o
);
  localparam int unsigned NCH = 3;

  logic        rd_ev, wr_ev, bad;
  logic [2:0]  ev_addr;
  byte_t       ev_data, ind_rdata, err_head, ir_q, ir_d, ir_set;
  logic        err_empty, err_full, err_over, err_under;
  logic [NCH-1:0]        tx_full, tx_over, rx_empty, rx_over, rx_under;
  logic [NCH-1:0][BW-1:0] rx_head;

  hbus_sync #(.AW(3), .DW(BW)) u_sync (
    .clk_i, .rst_ni, .cs_ni, .rd_ni, .wr_ni, .addr_i, .data_i,
    .rd_ev_o(rd_ev), .wr_ev_o(wr_ev), .bad_o(bad),
    .ev_addr_o(ev_addr), .ev_data_o(ev_data)
  );

  hbus_ind #(.NUM_GRP(NUM_GRP), .GRP_SZ(GRP_SZ)) u_ind (
    .clk_i, .rst_ni,
    .cmd_wr_i(wr_ev && ev_addr == A_CMD_IR),
    .dat_wr_i(wr_ev && ev_addr == A_DATA),
    .dat_rd_i(rd_ev && ev_addr == A_DATA),
    .wdata_i(ev_data),
    .rdata_o(ind_rdata),
    .bank_o
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int unsigned DEP = (c == 0) ? D_DEPTH : B_DEPTH;
    localparam logic [2:0] CH_A = 3'(A_CH_D) + 3'(c);
    logic push_h, pop_h;
    assign push_h = wr_ev && ev_addr == CH_A;
    assign pop_h  = rd_ev && ev_addr == CH_A;

    hbus_fifo #(.DEPTH(DEP), .W(BW)) u_tx (
      .clk_i, .rst_ni, .push_i(push_h), .wdata_i(ev_data),
      .pop_i(ctx_pop_i[c]), .rdata_o(ctx_data_o[c]),
      .empty_o(ctx_empty_o[c]), .full_o(tx_full[c])
    );
    hbus_fifo #(.DEPTH(DEP), .W(BW)) u_rx (
      .clk_i, .rst_ni, .push_i(crx_push_i[c]), .wdata_i(crx_data_i[c]),
      .pop_i(pop_h), .rdata_o(rx_head[c]),
      .empty_o(rx_empty[c]), .full_o(crx_full_o[c])
    );
    assign tx_over[c]  = push_h & tx_full[c];
    assign rx_over[c]  = crx_push_i[c] & crx_full_o[c];
    assign rx_under[c] = pop_h & rx_empty[c];
  end

  hbus_fifo #(.DEPTH(ERR_DEPTH), .W(BW)) u_err (
    .clk_i, .rst_ni, .push_i(err_push_i), .wdata_i(err_data_i),
    .pop_i(rd_ev && ev_addr == A_ERR), .rdata_o(err_head),
    .empty_o(err_empty), .full_o(err_full)
  );
  assign err_over  = err_push_i & err_full;
  assign err_under = rd_ev & (ev_addr == A_ERR) & err_empty;

  always_comb begin
    ir_set           = '0;
    ir_set[IR_UNDER] = |rx_under | err_under;
    ir_set[IR_OVER]  = |tx_over | |rx_over | err_over;
    ir_set[IR_PROTO] = bad;
    ir_set[BW-1:IR_EXT] = irq_src_i;
    ir_d = ((rd_ev && ev_addr == A_CMD_IR) ? '0 : ir_q) | ir_set;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ir_q <= '0;
    else         ir_q <= ir_d;
  end

  assign irq_o     = |(ir_q & ~bank_o[0]);
  assign data_oe_o = ~cs_ni & ~rd_ni & wr_ni;

  always_comb begin
    unique case (addr_i)
      3'd0:    data_o = ir_q;
      3'd1:    data_o = ind_rdata;
      3'd2:    data_o = stat1_i;
      3'd3:    data_o = err_head;
      3'd4:    data_o = rx_head[0];
      3'd5:    data_o = rx_head[1];
      3'd6:    data_o = rx_head[2];
      default: data_o = stat2_i;
    endcase
  end

  a_r2_ir_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ev && ev_addr == A_CMD_IR && ir_set == '0) |=> ir_q == '0);
  a_r9_proto_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad |=> ir_q[IR_PROTO]);
  a_r10_irq_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ir_q != '0);
  a_r2_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(rd_ev && ev_addr == A_CMD_IR)) |=> (ir_q & $past(ir_q)) == $past(ir_q));
endmodule

// File: tb/test_hbus_regif.sv
`timescale 1ns/1ps
module test_hbus_regif;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] din = '0, dout;
  logic oe, irq;
  logic [2:0] ctx_pop = '0, ctx_empty, crx_push = '0, crx_full;
  logic [2:0][7:0] ctx_data, crx_data = '0;
  logic err_push = 1'b0;
  logic [7:0] err_data = '0, stat1 = 8'hA5, stat2 = 8'h3C;
  logic [4:0] irq_src = '0;
  logic [63:0][7:0] bank;

  always #2 clk = ~clk;

  hbus_regif i_hbus_regif (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rd_ni(rd_n), .wr_ni(wr_n),
    .addr_i(addr), .data_i(din), .data_o(dout), .data_oe_o(oe), .irq_o(irq),
    .ctx_pop_i(ctx_pop), .ctx_data_o(ctx_data), .ctx_empty_o(ctx_empty),
    .crx_push_i(crx_push), .crx_data_i(crx_data), .crx_full_o(crx_full),
    .err_push_i(err_push), .err_data_i(err_data), .stat1_i(stat1), .stat2_i(stat2),
    .irq_src_i(irq_src), .bank_o(bank)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // reference model
  logic [7:0] exp_ir = '0;
  logic [7:0] bank_m [64];
  bit act_m = 0;
  int grp_m = 0, off_m = 0;
  logic [7:0] txq0[$], txq1[$], txq2[$], rxq0[$], rxq1[$], rxq2[$];

  function automatic int glen(int g); return ((g % 4) + 1) * 2; endfunction
  function automatic int dep(int c); return (c == 0) ? 8 : 4; endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus(input bit rd, input bit sel, input logic [2:0] a,
                     input logic [7:0] d, output logic [7:0] q);
    @(negedge clk); addr = a; din = d; cs_n = !sel;
    @(negedge clk); if (rd) rd_n = 1'b0; else wr_n = 1'b0;
    repeat (3) @(negedge clk);
    q = dout;
    rd_n = 1'b1; wr_n = 1'b1;
    repeat (5) @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic hwr(input logic [2:0] a, input logic [7:0] d);
    logic [7:0] q;
    bus(1'b0, 1'b1, a, d, q);
  endtask

  task automatic hrd(input logic [2:0] a, output logic [7:0] q);
    bus(1'b1, 1'b1, a, 8'h00, q);
  endtask

  task automatic bad_cycle(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; din = d; cs_n = 1'b0;
    @(negedge clk); rd_n = 1'b0; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    rd_n = 1'b1; wr_n = 1'b1;
    repeat (5) @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic core_pop(input int c, output logic e, output logic [7:0] d);
    @(negedge clk); e = ctx_empty[c]; d = ctx_data[c]; ctx_pop[c] = 1'b1;
    @(negedge clk); ctx_pop[c] = 1'b0;
  endtask

  task automatic core_push(input int c, input logic [7:0] d);
    @(negedge clk); crx_data[c] = d; crx_push[c] = 1'b1;
    @(negedge clk); crx_push[c] = 1'b0;
  endtask

  // model-tracked operations
  task automatic m_cmd(input logic [7:0] d);
    hwr(3'd0, d);
    act_m = (d[7:6] == 2'b00); grp_m = int'(d[5:3]); off_m = int'(d[2:0]);
  endtask

  task automatic m_data(input bit rd, input logic [7:0] wd, input string tag);
    logic [7:0] q, e;
    bit inr;
    inr = act_m && off_m < glen(grp_m);
    e = inr ? bank_m[grp_m * 8 + off_m] : 8'h00;
    if (rd) begin
      hrd(3'd1, q);
      chk(tag, q, e);
    end else begin
      hwr(3'd1, wd);
      if (inr) bank_m[grp_m * 8 + off_m] = wd;
    end
    if (act_m) off_m = (off_m + 1 >= glen(grp_m)) ? 0 : off_m + 1;
  endtask

  task automatic m_tx_push(input int c, input logic [7:0] d);
    int sz;
    hwr(3'(4 + c), d);
    sz = (c == 0) ? txq0.size() : (c == 1) ? txq1.size() : txq2.size();
    if (sz >= dep(c)) exp_ir[1] = 1'b1;
    else if (c == 0) txq0.push_back(d);
    else if (c == 1) txq1.push_back(d);
    else txq2.push_back(d);
  endtask

  task automatic m_tx_pop(input int c, input string tag);
    logic e;
    logic [7:0] d, x;
    int sz;
    core_pop(c, e, d);
    sz = (c == 0) ? txq0.size() : (c == 1) ? txq1.size() : txq2.size();
    chk(tag, e, (sz == 0));
    if (sz != 0) begin
      x = (c == 0) ? txq0.pop_front() : (c == 1) ? txq1.pop_front() : txq2.pop_front();
      chk(tag, d, x);
    end
  endtask

  task automatic m_rx_push(input int c, input logic [7:0] d);
    int sz;
    core_push(c, d);
    sz = (c == 0) ? rxq0.size() : (c == 1) ? rxq1.size() : rxq2.size();
    if (sz >= dep(c)) exp_ir[1] = 1'b1;
    else if (c == 0) rxq0.push_back(d);
    else if (c == 1) rxq1.push_back(d);
    else rxq2.push_back(d);
  endtask

  task automatic m_rx_pop(input int c, input string tag);
    logic [7:0] q, x;
    int sz;
    hrd(3'(4 + c), q);
    sz = (c == 0) ? rxq0.size() : (c == 1) ? rxq1.size() : rxq2.size();
    if (sz == 0) begin x = 8'h00; exp_ir[0] = 1'b1; end
    else x = (c == 0) ? rxq0.pop_front() : (c == 1) ? rxq1.pop_front() : rxq2.pop_front();
    chk(tag, q, x);
  endtask

  task automatic m_ir(input string tag);
    logic [7:0] q;
    chk({tag, " irq"}, irq, ((exp_ir & ~bank_m[0]) != 8'h00));
    hrd(3'd0, q);
    chk(tag, q, exp_ir);
    exp_ir = '0;
  endtask

  task automatic pulse_src(input logic [4:0] v);
    @(negedge clk); irq_src = v;
    @(negedge clk); irq_src = '0;
    exp_ir = exp_ir | {v, 3'b000};
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [7:0] q;
    logic e;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) bank_m[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R11 reset state
    chk("R11 irq", irq, 0);
    chk("R11 tx empty", ctx_empty, 3'b111);
    chk("R11 rx full", crx_full, 3'b000);
    chk("R11 bank", bank[5], 8'h00);
    m_ir("R11 ir");
    m_data(1'b1, 8'h00, "R11 no transfer open");

    // R12 drive enable
    chk("R12 oe idle", oe, 0);
    @(negedge clk); addr = 3'd2; cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk); chk("R12 oe read", oe, 1); chk("R5 stat1", dout, 8'hA5);
    rd_n = 1'b1; @(negedge clk); chk("R12 oe released", oe, 0);
    repeat (5) @(negedge clk); cs_n = 1'b1;

    // R5 status and write-ignored addresses
    hrd(3'd7, q); chk("R5 stat2", q, 8'h3C);
    hwr(3'd2, 8'h11); hwr(3'd3, 8'h22); hwr(3'd7, 8'h33);
    hrd(3'd3, q); chk("R5 write 3 not pushed", q, 8'h00);
    exp_ir[0] = 1'b1;
    m_ir("R5 write 2/3/7 no effect");

    // R6 error FIFO
    @(negedge clk); err_data = 8'h11; err_push = 1'b1;
    @(negedge clk); err_data = 8'h22;
    @(negedge clk); err_data = 8'h33;
    @(negedge clk); err_push = 1'b0;
    exp_ir[1] = 1'b1;
    hrd(3'd3, q); chk("R6 err first", q, 8'h11);
    hrd(3'd3, q); chk("R6 err second", q, 8'h22);
    hrd(3'd3, q); chk("R8 err empty pop", q, 8'h00);
    exp_ir[0] = 1'b1;
    m_ir("R2 ir bits 0,1");
    m_ir("R2 ir cleared by read");

    // R3 auto-increment and wrap
    m_cmd(8'h1E);
    for (int i = 0; i < 4; i++) m_data(1'b0, 8'hA0 + 8'(i), "R3");
    chk("R3 wrap to offset 0", bank[24], 8'hA2);
    m_cmd(8'h1E);
    for (int i = 0; i < 4; i++) m_data(1'b1, 8'h00, "R3 readback wrap");
    m_cmd(8'h21);
    m_data(1'b0, 8'h55, "R3"); m_data(1'b0, 8'h66, "R3");
    m_cmd(8'h20);
    for (int i = 0; i < 3; i++) m_data(1'b1, 8'h00, "R3 short group wrap");
    m_cmd(8'h0E);
    m_data(1'b0, 8'h77, "R3"); m_data(1'b0, 8'h88, "R3");
    m_cmd(8'h08);
    m_data(1'b1, 8'h00, "R3 out-of-range then offset 0");
    chk("R3 bank g1 o0", bank[8], 8'h88);

    // R4 command ends transfer
    m_cmd(8'h20); m_data(1'b1, 8'h00, "R4");
    m_cmd(8'h20); m_data(1'b1, 8'h00, "R4 restart at new offset");
    m_cmd(8'hE0);
    m_data(1'b0, 8'h99, "R4"); m_data(1'b1, 8'h00, "R4 cancelled read zero");
    m_cmd(8'h20); m_data(1'b1, 8'h00, "R4 cancelled write dropped");

    // R1 unselected accesses
    bus(1'b0, 1'b0, 3'd4, 8'h5A, q);
    chk("R1 unselected push", ctx_empty[0], 1);
    pulse_src(5'b00001);
    bus(1'b1, 1'b0, 3'd0, 8'h00, q);
    chk("R1 unselected read keeps irq", irq, 1);
    bus(1'b0, 1'b0, 3'd0, 8'h00, q);
    m_data(1'b1, 8'h00, "R1 unselected command ignored");
    m_ir("R1 ir kept");

    // R10 mask
    pulse_src(5'b00010);
    chk("R10 irq set", irq, 1);
    m_cmd(8'h00); m_data(1'b0, 8'h10, "R10");
    chk("R10 irq masked", irq, 0);
    m_ir("R10 ir under mask");
    m_cmd(8'h00); m_data(1'b0, 8'h00, "R10");

    // R9 overlapped strobes
    bad_cycle(3'd4, 8'hEE);
    chk("R9 no push", ctx_empty[0], 1);
    exp_ir[2] = 1'b1;
    chk("R9 irq", irq, 1);
    m_ir("R9 proto bit");

    // R7 once per strobe, order, depth
    for (int i = 0; i < 3; i++) m_tx_push(1, 8'h40 + 8'(i));
    for (int i = 0; i < 4; i++) m_tx_pop(1, "R7 bb order");
    for (int i = 0; i < 5; i++) m_tx_push(2, 8'h50 + 8'(i));
    for (int i = 0; i < 5; i++) m_tx_pop(2, "R7 bc depth");
    for (int i = 0; i < 9; i++) m_rx_push(0, 8'h60 + 8'(i));
    chk("R8 rx full", crx_full[0], 1);
    for (int i = 0; i < 9; i++) m_rx_pop(0, "R8 rx order and empty pop");
    m_ir("R8 over and under bits");

    // constrained random
    for (int n = 0; n < 300; n++) begin
      int op, c;
      op = int'($urandom_range(0, 7));
      c  = int'($urandom_range(0, 2));
      case (op)
        0: m_cmd({($urandom_range(0, 4) == 0) ? 2'b10 : 2'b00, 6'($urandom)});
        1: m_data(1'b0, 8'($urandom), "R3 rand");
        2: m_data(1'b1, 8'h00, "R3 rand read");
        3: m_tx_push(c, 8'($urandom));
        4: m_tx_pop(c, "R7 rand tx");
        5: m_rx_push(c, 8'($urandom));
        6: m_rx_pop(c, "R7 rand rx");
        default: m_ir("R2 rand ir");
      endcase
    end
    m_ir("R2 final ir");
    e = 1'b0; q = '0;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule